// File: doc/BRIEF.md
# Macro-Instruction Dispatch Substitution Engine

This engine sits in the front end between decode and rename. Each decoded instruction's PC is offered to a chain lookup port. A stored chain is a linear run of three dependent ALU instructions joined by single-use temporaries. When the first member's PC hits and the lookup says the chain's inputs are ready, the engine sends one macro-instruction to rename in that member's place. While the chain is pending, the engine swallows the two later members as they arrive, in order.

Skipping members has side effects, and the engine tracks them. The chain's two intermediate registers are never written, so they are marked dirty. A later reader of a dirty register is preceded by a recovery action that rebuilds the value. The chain's final destination is written early, so a reader that arrives while members are still pending is preceded by a restore of the older value. A taken branch whose target is not the next expected member drops the chain and raises a one-cycle kill. Output is one item per cycle, with a valid/ready handshake.

Top module: `macro_dispatch_sub`

## Requirements
- R1: After reset, with no input offered, `out_valid` and `kill` are low.
- R2: If the lookup misses, the instruction goes out in the same cycle with kind 0 (pass) and `out_reg` equal to its destination.
- R3: If no chain is pending and the lookup reports both hit and ready, one item of kind 1 (macro) goes out in place of the head instruction. It carries the head's PC and `out_reg` equal to the chain's final destination.
- R4: A lookup hit that is not ready passes the instruction on as kind 0.
- R5: Once a chain is inserted, its second and third member PCs are consumed in that order with `out_valid` low and `in_ready` high. Other instructions between them pass normally.
- R6: Insertion marks both intermediate registers dirty. An instruction reading a dirty register is preceded by one kind 2 (recovery) item naming that register, during which `in_ready` is low. The recovery clears the register's dirty mark.
- R7: A passed instruction that writes a register clears that register's dirty mark, so a later reader gets no recovery.
- R8: While members are pending, an instruction reading the chain's final destination is preceded by exactly one kind 3 (restore) item naming that register. After the last member has been consumed, no restore is issued.
- R9: If both sources are dirty, the source-1 recovery goes first, then the source-2 recovery, then the instruction.
- R10: An accepted taken branch (`in_br`) whose `in_tgt` differs from the next pending member PC raises `kill` for exactly the following cycle and drops the chain. A later arrival of an old member PC then passes as kind 0.
- R11: Only one chain is pending at a time. A ready lookup hit while a chain is pending passes as kind 0.
- R12: While `out_valid` is high and `out_ready` is low, `in_ready` is low, so no instruction is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction consumed this cycle |
| in_pc | input | PCW | Instruction PC |
| in_src1 | input | RW | Source register 1 |
| in_rd1 | input | 1 | Source 1 is read |
| in_src2 | input | RW | Source register 2 |
| in_rd2 | input | 1 | Source 2 is read |
| in_dst | input | RW | Destination register |
| in_wr | input | 1 | Destination is written |
| in_br | input | 1 | Instruction is a taken branch |
| in_tgt | input | PCW | Branch target |
| lk_pc | output | PCW | PC presented to chain lookup |
| lk_hit | input | 1 | A chain starts at `lk_pc` |
| lk_ready | input | 1 | The chain's inputs are ready |
| lk_pc1 | input | PCW | Second member PC |
| lk_pc2 | input | PCW | Third member PC |
| lk_mid1 | input | RW | First intermediate register |
| lk_mid2 | input | RW | Second intermediate register |
| lk_dst | input | RW | Chain final destination |
| out_valid | output | 1 | Item offered to rename |
| out_ready | input | 1 | Rename accepts the item |
| out_kind | output | 2 | 0 pass, 1 macro, 2 recovery, 3 restore |
| out_pc | output | PCW | PC of the instruction in the input slot |
| out_reg | output | RW | Destination, or the register recovered or restored |
| kill | output | 1 | Pending chain abandoned |

## Verification
Two decisions can fall on the same instruction: its source checks against the dirty table, and its role with respect to the pending chain (member, chain-destination reader, or mismatching branch). The bench provokes this in three ways. It sends a reader with two dirty sources while a chain is pending. It sends a reader of the chain's destination between two members. It sends a taken branch whose target skips the next member. Each cycle is judged by the item kind, the named register and `in_ready`. The branch case is also judged by the kill pulse one cycle later and by the old member PC then passing as an ordinary instruction.

// File: rtl/macro_dispatch_sub.sv
module macro_dispatch_sub #(
  parameter int PCW = 16,
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [PCW-1:0] in_pc,
  input  logic [RW-1:0]  in_src1,
  input  logic           in_rd1,
  input  logic [RW-1:0]  in_src2,
  input  logic           in_rd2,
  input  logic [RW-1:0]  in_dst,
  input  logic           in_wr,
  input  logic           in_br,
  input  logic [PCW-1:0] in_tgt,
  output logic [PCW-1:0] lk_pc,
  input  logic           lk_hit,
  input  logic           lk_ready,
  input  logic [PCW-1:0] lk_pc1,
  input  logic [PCW-1:0] lk_pc2,
  input  logic [RW-1:0]  lk_mid1,
  input  logic [RW-1:0]  lk_mid2,
  input  logic [RW-1:0]  lk_dst,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [1:0]     out_kind,
  output logic [PCW-1:0] out_pc,
  output logic [RW-1:0]  out_reg,
  output logic           kill
);
  localparam logic [1:0] K_PASS = 2'd0, K_MACRO = 2'd1, K_RECOV = 2'd2, K_REST = 2'd3;

  logic [NREG-1:0] dirty;
  logic [1:0]      cnt;
  logic [PCW-1:0]  m1, m2;
  logic [RW-1:0]   cdst;
  logic            rs_done, kill_q;

  logic [PCW-1:0] nxt;
  logic active, member, ins, need_r1, need_r2, need_rs, main_ph, acc, fire, brk, hits_cd;

  assign lk_pc   = in_pc;
  assign active  = cnt != 2'd0;
  assign nxt     = (cnt == 2'd2) ? m1 : m2;
  assign member  = active && in_pc == nxt;
  assign ins     = !active && lk_hit && lk_ready;
  assign need_r1 = !member && in_rd1 && dirty[in_src1];
  assign need_r2 = !member && in_rd2 && dirty[in_src2];
  assign hits_cd = (in_rd1 && in_src1 == cdst) || (in_rd2 && in_src2 == cdst);
  assign need_rs = !member && !ins && active && !rs_done && hits_cd;
  assign main_ph = !need_r1 && !need_r2 && !need_rs;

  assign out_kind  = (need_r1 || need_r2) ? K_RECOV : need_rs ? K_REST : ins ? K_MACRO : K_PASS;
  assign out_reg   = need_r1 ? in_src1 : need_r2 ? in_src2 : need_rs ? cdst : ins ? lk_dst : in_dst;
  assign out_pc    = in_pc;
  assign out_valid = in_valid && !(main_ph && member);
  assign in_ready  = main_ph && (member || out_ready);
  assign kill      = kill_q;

  assign acc  = in_valid && in_ready;
  assign fire = out_valid && out_ready;
  assign brk  = acc && !member && in_br && active && in_tgt != nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty   <= '0;
      cnt     <= 2'd0;
      m1      <= '0;
      m2      <= '0;
      cdst    <= '0;
      rs_done <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      kill_q <= brk;
      if (fire && out_kind == K_RECOV) dirty[out_reg] <= 1'b0;
      if (fire && out_kind == K_REST) rs_done <= 1'b1;
      if (acc) begin
        rs_done <= 1'b0;
        if (member) cnt <= cnt - 2'd1;
        else begin
          if (brk) cnt <= 2'd0;
          if (ins) begin
            cnt  <= 2'd2;
            m1   <= lk_pc1;
            m2   <= lk_pc2;
            cdst <= lk_dst;
            dirty[lk_mid1] <= 1'b1;
            dirty[lk_mid2] <= 1'b1;
          end else if (in_wr) dirty[in_dst] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/macro_dispatch_sub_chk.sv
module macro_dispatch_sub_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_kind,
  input logic       kill
);
  a_r10_kill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !kill);
  a_r12_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r11_one_chain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_kind == 2'd1 |=> !(out_valid && out_kind == 2'd1));
  a_r6_recov_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd2 |-> !in_ready);
  a_r8_restore_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd3 |-> !in_ready);
endmodule

bind macro_dispatch_sub macro_dispatch_sub_chk chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .kill(kill)
);

// File: tb/tb_macro_dispatch_sub.sv
module tb_macro_dispatch_sub;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [15:0] in_pc = 0, in_tgt = 0, lk_pc, lk_pc1 = 0, lk_pc2 = 0, out_pc;
  logic [4:0] in_src1 = 0, in_src2 = 0, in_dst = 0, lk_mid1 = 0, lk_mid2 = 0, lk_dst = 0, out_reg;
  logic in_rd1 = 0, in_rd2 = 0, in_wr = 0, in_br = 0, lk_hit = 0, lk_ready = 0;
  logic out_valid, out_ready = 1, kill;
  logic [1:0] out_kind;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  macro_dispatch_sub dut (.*);

  task automatic cmp(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(input bit ev, input int ek, input int er, input bit erdy, input bit ekill, input string tag);
    #8;
    cmp(out_valid, ev, {tag, " valid"});
    if (ev) begin
      cmp(out_kind, ek, {tag, " kind"});
      cmp(out_reg, er, {tag, " reg"});
    end
    cmp(in_ready, erdy, {tag, " in_ready"});
    cmp(kill, ekill, {tag, " kill"});
    @(negedge clk);
  endtask

  task automatic put(input int pc, input int s1, input bit r1, input int s2, input bit r2, input int dst, input bit wr);
    in_valid = 1; in_pc = 16'(pc); in_src1 = 5'(s1); in_rd1 = r1; in_src2 = 5'(s2); in_rd2 = r2;
    in_dst = 5'(dst); in_wr = wr; in_br = 0; lk_hit = 0; lk_ready = 0;
  endtask

  task automatic chain(input int p1, input int p2, input int a, input int b, input int d);
    lk_hit = 1; lk_ready = 1; lk_pc1 = 16'(p1); lk_pc2 = 16'(p2);
    lk_mid1 = 5'(a); lk_mid2 = 5'(b); lk_dst = 5'(d);
  endtask

  task automatic t_reset;
    in_valid = 0;
    look(0, 0, 0, 1, 0, "R1 reset idle");
  endtask

  task automatic t_pass;
    put(16'h100, 1, 1, 2, 1, 5, 1);
    look(1, 0, 5, 1, 0, "R2 miss passes");
    put(16'h104, 0, 0, 0, 0, 6, 1); lk_hit = 1;
    look(1, 0, 6, 1, 0, "R4 hit not ready passes");
  endtask

  task automatic t_chain;
    put(16'h200, 0, 0, 0, 0, 3, 1); chain(16'h204, 16'h210, 3, 4, 7);
    look(1, 1, 7, 1, 0, "R3 macro inserted");
    put(16'h300, 3, 1, 0, 0, 9, 1);
    look(1, 2, 3, 0, 0, "R6 recovery first");
    look(1, 0, 9, 1, 0, "R6 instruction after recovery");
    put(16'h304, 3, 1, 0, 0, 10, 1);
    look(1, 0, 10, 1, 0, "R6 dirty cleared by recovery");
    put(16'h204, 0, 0, 0, 0, 3, 1);
    look(0, 0, 0, 1, 0, "R5 member 2 suppressed");
    put(16'h308, 0, 0, 0, 0, 11, 1); chain(16'h30c, 16'h310, 1, 2, 8);
    look(1, 0, 11, 1, 0, "R11 second chain not inserted");
    put(16'h30c, 0, 0, 7, 1, 12, 1);
    look(1, 3, 7, 0, 0, "R8 restore first");
    look(1, 0, 12, 1, 0, "R8 one restore then instruction");
    put(16'h210, 0, 0, 0, 0, 4, 1);
    look(0, 0, 0, 1, 0, "R5 member 3 suppressed");
    put(16'h214, 0, 0, 7, 1, 13, 1);
    look(1, 0, 13, 1, 0, "R8 no restore after chain done");
  endtask

  task automatic t_clear;
    put(16'h400, 0, 0, 0, 0, 4, 1);
    look(1, 0, 4, 1, 0, "R7 writer passes");
    put(16'h404, 4, 1, 0, 0, 14, 1);
    look(1, 0, 14, 1, 0, "R7 reader after write no recovery");
  endtask

  task automatic t_two_dirty;
    put(16'h500, 0, 0, 0, 0, 1, 1); chain(16'h504, 16'h508, 1, 2, 8);
    look(1, 1, 8, 1, 0, "R3 second macro");
    put(16'h510, 1, 1, 2, 1, 15, 1);
    look(1, 2, 1, 0, 0, "R9 src1 recovery first");
    look(1, 2, 2, 0, 0, "R9 src2 recovery second");
    look(1, 0, 15, 1, 0, "R9 instruction last");
  endtask

  task automatic t_kill;
    put(16'h520, 0, 0, 0, 0, 0, 0); in_br = 1; in_tgt = 16'h600;
    look(1, 0, 0, 1, 0, "R10 branch passes");
    put(16'h504, 0, 0, 0, 0, 16, 1);
    look(1, 0, 16, 1, 1, "R10 kill and old member passes");
    in_valid = 0;
    look(0, 0, 0, 1, 0, "R10 kill one cycle");
  endtask

  task automatic t_stall;
    put(16'h700, 0, 0, 0, 0, 17, 1); out_ready = 0;
    look(1, 0, 17, 0, 0, "R12 held while stalled");
    out_ready = 1;
    look(1, 0, 17, 1, 0, "R12 released");
    in_valid = 0;
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pass();
    t_chain();
    t_clear();
    t_two_dirty();
    t_kill();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule